// File: doc/BRIEF.md
# Cross-Clock Mailbox Register Pair

This block lets two ports on unrelated clocks pass single command words to each other without a queue. Each direction has one storage register: the outbound register of port A is read on port B, and the outbound register of port B is read on port A. A port loads its outbound register with a mailbox write and then sees an active-low flag that stays low until the other side has taken the word. While that flag is low, further writes from the owner are dropped. That keeps the stored word stable, so the reading port can take it directly across the boundary.

Writes and reads are passed across as toggles through two-flop synchronizers. Each flag lives in exactly one clock domain. On the reading side, a mirror bit marks that a word is waiting. Only a read that finds this bit set sends a release back to the writer. Reads never alter the stored word. On each port, a select input steers the data output either to the inbound mailbox or to the FIFO output-register bus that the port already has.

Top module: `mbx_pair`

## Requirements
- R1: On a rising edge of `clk_a` with `a_en`=1, `a_wr`=1, `a_mbx_sel`=1 and `a_tx_full_n`=1, `a_din` is stored as the port-A outbound word, and `a_tx_full_n` reads 0 after that edge.
- R2: A port-A mailbox write made while `a_tx_full_n` is 0 is dropped. The stored word keeps its earlier value, and a later read on port B returns that earlier value.
- R3: `b_rx_avail` goes to 1 after the third rising edge of `clk_b` that follows an accepted port-A write.
- R4: A rising edge of `clk_b` with `b_en`=1, `b_wr`=0, `b_mbx_sel`=1 and `b_rx_avail`=1 clears `b_rx_avail`. After the third rising edge of `clk_a` that follows that read, `a_tx_full_n` returns to 1. A read made while `b_rx_avail` is 0 changes no flag.
- R5: A stored word changes only on an accepted write. Reads leave it intact, so repeated reads return the same value.
- R6: The port-B outbound direction mirrors R1 to R4 with the roles of the two ports swapped. The signals involved are `b_tx_full_n`, `a_rx_avail`, `clk_b` and `clk_a`.
- R7: `a_dout` equals the port-B outbound word when `a_mbx_sel`=1 and equals `a_fifo_q` when it is 0. `b_dout` does the same with the port-A outbound word and `b_fifo_q`.
- R8: While `rst_n` is 0 and after its release, both stored words are zero, both `*_tx_full_n` flags are 1 and both `*_rx_avail` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, unrelated to clk_a |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_en | input | 1 | Port A transfer enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mbx_sel | input | 1 | Port A selects mailbox (1) or FIFO path (0) |
| a_din | input | W | Port A write data |
| a_fifo_q | input | W | Port A FIFO output register contents |
| a_dout | output | W | Port A read data |
| a_tx_full_n | output | 1 | Port A outbound word not yet taken (active low) |
| a_rx_avail | output | 1 | Port B word waiting for port A |
| b_en | input | 1 | Port B transfer enable |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_mbx_sel | input | 1 | Port B selects mailbox (1) or FIFO path (0) |
| b_din | input | W | Port B write data |
| b_fifo_q | input | W | Port B FIFO output register contents |
| b_dout | output | W | Port B read data |
| b_tx_full_n | output | 1 | Port B outbound word not yet taken (active low) |
| b_rx_avail | output | 1 | Port A word waiting for port B |

## Verification
The properties assume that every port input is steady around the rising edge of its own clock and that `rst_n` is applied to both domains together. They also assume that the two clocks never share an edge, so a toggle is first seen by exactly one later edge of the other clock. The stimulus drives each port's inputs only on that port's falling edge. The two clock periods are chosen so that their rising edges never coincide. Reset is held low across several edges of both clocks before any traffic starts.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned MBX_DATA_W   = 36;
    localparam int unsigned MBX_SYNC_LEN = 2;
    localparam int unsigned MBX_CHANNELS = 2;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int unsigned STAGES = mbx_pkg::MBX_SYNC_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_i,
    output logic tog_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = tog_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], tog_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign tog_o = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
    parameter int unsigned W      = mbx_pkg::MBX_DATA_W,
    parameter int unsigned STAGES = mbx_pkg::MBX_SYNC_LEN
) (
    input  logic         wclk,
    input  logic         rclk,
    input  logic         rst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wdata,
    input  logic         rd_req,
    output logic [W-1:0] data_o,
    output logic         full_n_o,
    output logic         avail_o
);
    typedef struct packed {
        logic [W-1:0] data;
        logic         full_n;
        logic         tog;
        logic         ack_seen;
    } wr_st_t;

    typedef struct packed {
        logic pend;
        logic tog;
        logic wr_seen;
    } rd_st_t;

    wr_st_t w_d, w_q;
    rd_st_t r_d, r_q;
    logic   wtog_r, rtog_w;

    mbx_sync #(.STAGES(STAGES)) u_w2r (
        .clk  (rclk),
        .rst_n(rst_n),
        .tog_i(w_q.tog),
        .tog_o(wtog_r)
    );

    mbx_sync #(.STAGES(STAGES)) u_r2w (
        .clk  (wclk),
        .rst_n(rst_n),
        .tog_i(r_q.tog),
        .tog_o(rtog_w)
    );

    // writer domain: owns the word and the active-low flag
    always_comb begin
        w_d = w_q;
        if (rtog_w != w_q.ack_seen) begin
            w_d.ack_seen = rtog_w;
            w_d.full_n   = 1'b1;
        end
        if (wr_req && w_q.full_n) begin
            w_d.data   = wdata;
            w_d.full_n = 1'b0;
            w_d.tog    = ~w_q.tog;
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) w_q <= '{data: '0, full_n: 1'b1, tog: 1'b0, ack_seen: 1'b0};
        else        w_q <= w_d;
    end

    // reader domain: mirror bit, releases only a word it has seen arrive
    always_comb begin
        r_d = r_q;
        if (rd_req && r_q.pend) begin
            r_d.pend = 1'b0;
            r_d.tog  = ~r_q.tog;
        end
        if (wtog_r != r_q.wr_seen) begin
            r_d.wr_seen = wtog_r;
            r_d.pend    = 1'b1;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign data_o   = w_q.data;
    assign full_n_o = w_q.full_n;
    assign avail_o  = r_q.pend;
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair #(
    parameter int unsigned W      = mbx_pkg::MBX_DATA_W,
    parameter int unsigned STAGES = mbx_pkg::MBX_SYNC_LEN
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         rst_n,
    input  logic         a_en,
    input  logic         a_wr,
    input  logic         a_mbx_sel,
    input  logic [W-1:0] a_din,
    input  logic [W-1:0] a_fifo_q,
    output logic [W-1:0] a_dout,
    output logic         a_tx_full_n,
    output logic         a_rx_avail,
    input  logic         b_en,
    input  logic         b_wr,
    input  logic         b_mbx_sel,
    input  logic [W-1:0] b_din,
    input  logic [W-1:0] b_fifo_q,
    output logic [W-1:0] b_dout,
    output logic         b_tx_full_n,
    output logic         b_rx_avail
);
    localparam int unsigned NCH = mbx_pkg::MBX_CHANNELS;

    // index 0: A writes, B reads; index 1: B writes, A reads
    logic [NCH-1:0] wclk_v, rclk_v, wr_v, rd_v, full_v, avail_v;
    logic [W-1:0]   wdata_v [NCH];
    logic [W-1:0]   word_v  [NCH];
    logic [W-1:0]   mail1_q, mail2_q;

    always_comb begin
        wclk_v     = {clk_b, clk_a};
        rclk_v     = {clk_a, clk_b};
        wr_v[0]    = a_en & a_wr & a_mbx_sel;
        wr_v[1]    = b_en & b_wr & b_mbx_sel;
        rd_v[0]    = b_en & ~b_wr & b_mbx_sel;
        rd_v[1]    = a_en & ~a_wr & a_mbx_sel;
        wdata_v[0] = a_din;
        wdata_v[1] = b_din;
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            mbx_channel #(.W(W), .STAGES(STAGES)) u_ch (
                .wclk    (wclk_v[g]),
                .rclk    (rclk_v[g]),
                .rst_n   (rst_n),
                .wr_req  (wr_v[g]),
                .wdata   (wdata_v[g]),
                .rd_req  (rd_v[g]),
                .data_o  (word_v[g]),
                .full_n_o(full_v[g]),
                .avail_o (avail_v[g])
            );
        end
    endgenerate

    always_comb begin
        mail1_q     = word_v[0];
        mail2_q     = word_v[1];
        a_dout      = a_mbx_sel ? mail2_q : a_fifo_q;
        b_dout      = b_mbx_sel ? mail1_q : b_fifo_q;
        a_tx_full_n = full_v[0];
        b_tx_full_n = full_v[1];
        b_rx_avail  = avail_v[0];
        a_rx_avail  = avail_v[1];
    end
endmodule

// File: rtl/mbx_pair_chk.sv
module mbx_pair_chk #(
    parameter int unsigned W = mbx_pkg::MBX_DATA_W
) (
    input logic         clk_a,
    input logic         clk_b,
    input logic         rst_n,
    input logic         a_en,
    input logic         a_wr,
    input logic         a_mbx_sel,
    input logic [W-1:0] a_din,
    input logic         a_tx_full_n,
    input logic         b_en,
    input logic         b_wr,
    input logic         b_mbx_sel,
    input logic [W-1:0] b_din,
    input logic         b_tx_full_n,
    input logic         b_rx_avail,
    input logic [W-1:0] mail1_q,
    input logic [W-1:0] mail2_q
);
    p_wr_accept_r1: assert property (@(posedge clk_a) disable iff (!rst_n)
        (a_en && a_wr && a_mbx_sel && a_tx_full_n) |=> (!a_tx_full_n && mail1_q == $past(a_din)))
        else $error("p_wr_accept_r1");

    p_wr_block_r2: assert property (@(posedge clk_a) disable iff (!rst_n)
        (a_en && a_wr && a_mbx_sel && !a_tx_full_n) |=> $stable(mail1_q))
        else $error("p_wr_block_r2");

    p_rd_clear_r4: assert property (@(posedge clk_b) disable iff (!rst_n)
        (b_en && !b_wr && b_mbx_sel && b_rx_avail) |=> !b_rx_avail)
        else $error("p_rd_clear_r4");

    p_word_keep_r5: assert property (@(posedge clk_a) disable iff (!rst_n)
        !(a_en && a_wr && a_mbx_sel && a_tx_full_n) |=> $stable(mail1_q))
        else $error("p_word_keep_r5");

    p_wr_accept_r6: assert property (@(posedge clk_b) disable iff (!rst_n)
        (b_en && b_wr && b_mbx_sel && b_tx_full_n) |=> (!b_tx_full_n && mail2_q == $past(b_din)))
        else $error("p_wr_accept_r6");
endmodule

bind mbx_pair mbx_pair_chk #(.W(W)) u_chk (
    .clk_a      (clk_a),
    .clk_b      (clk_b),
    .rst_n      (rst_n),
    .a_en       (a_en),
    .a_wr       (a_wr),
    .a_mbx_sel  (a_mbx_sel),
    .a_din      (a_din),
    .a_tx_full_n(a_tx_full_n),
    .b_en       (b_en),
    .b_wr       (b_wr),
    .b_mbx_sel  (b_mbx_sel),
    .b_din      (b_din),
    .b_tx_full_n(b_tx_full_n),
    .b_rx_avail (b_rx_avail),
    .mail1_q    (mail1_q),
    .mail2_q    (mail2_q)
);

// File: tb/mbx_pair_tb.sv
module mbx_pair_tb;
    localparam int W = 36;

    logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
    logic a_en = 0, a_wr = 0, a_mbx_sel = 0, b_en = 0, b_wr = 0, b_mbx_sel = 0;
    logic [W-1:0] a_din = '0, a_fifo_q = '0, b_din = '0, b_fifo_q = '0;
    logic [W-1:0] a_dout, b_dout;
    logic a_tx_full_n, a_rx_avail, b_tx_full_n, b_rx_avail;

    int checks = 0, failures = 0;
    bit done_a = 0, done_b = 0;

    // reference state
    logic [W-1:0] m1 = '0, m2 = '0;
    bit f1 = 1, f2 = 1, av1 = 0, av2 = 0;
    int t_w1 = 0, t_r1 = 0, t_w2 = 0, t_r2 = 0;

    mbx_pair #(.W(W)) u_dut (.*);

    always #10 clk_a = ~clk_a;  // 50 MHz
    always #7  clk_b = ~clk_b;  // rising edges never meet those of clk_a

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // reference model, port A edge
    always @(posedge clk_a) if (rst_n) begin
        if (a_en && a_wr && a_mbx_sel && f1) begin m1 = a_din; f1 = 0; t_w1 = 3; end
        if (a_en && !a_wr && a_mbx_sel && av2) begin av2 = 0; t_r2 = 3; end
        if (t_w2 > 0) begin t_w2--; if (t_w2 == 0) av2 = 1; end
        if (t_r1 > 0) begin t_r1--; if (t_r1 == 0) f1 = 1; end
    end

    // reference model, port B edge
    always @(posedge clk_b) if (rst_n) begin
        if (b_en && b_wr && b_mbx_sel && f2) begin m2 = b_din; f2 = 0; t_w2 = 3; end
        if (b_en && !b_wr && b_mbx_sel && av1) begin av1 = 0; t_r1 = 3; end
        if (t_w1 > 0) begin t_w1--; if (t_w1 == 0) av1 = 1; end
        if (t_r2 > 0) begin t_r2--; if (t_r2 == 0) f2 = 1; end
    end

    // per-clock comparison, away from both rising edges
    always @(negedge clk_a) if (rst_n) begin
        #2;
        check("R1 R2 R4 a_tx_full_n", W'(a_tx_full_n), W'(f1));
        check("R6 a_rx_avail", W'(a_rx_avail), W'(av2));
        check("R7 R5 R6 a_dout", a_dout, a_mbx_sel ? m2 : a_fifo_q);
    end

    always @(negedge clk_b) if (rst_n) begin
        #1;
        check("R3 R4 b_rx_avail", W'(b_rx_avail), W'(av1));
        check("R6 b_tx_full_n", W'(b_tx_full_n), W'(f2));
        check("R7 R5 R2 b_dout", b_dout, b_mbx_sel ? m1 : b_fifo_q);
    end

    task automatic drive_a(bit en, bit wr, bit sel, logic [W-1:0] d);
        @(negedge clk_a);
        a_en = en; a_wr = wr; a_mbx_sel = sel; a_din = d;
        a_fifo_q = W'({$urandom(), $urandom()});
    endtask

    task automatic drive_b(bit en, bit wr, bit sel, logic [W-1:0] d);
        @(negedge clk_b);
        b_en = en; b_wr = wr; b_mbx_sel = sel; b_din = d;
        b_fifo_q = W'({$urandom(), $urandom()});
    endtask

    initial begin
        repeat (4) @(negedge clk_a);
        #3;
        // R8: state during reset
        a_mbx_sel = 1; b_mbx_sel = 1;
        #1;
        check("R8 reset a_tx_full_n", W'(a_tx_full_n), W'(1));
        check("R8 reset b_tx_full_n", W'(b_tx_full_n), W'(1));
        check("R8 reset a_rx_avail", W'(a_rx_avail), W'(0));
        check("R8 reset b_rx_avail", W'(b_rx_avail), W'(0));
        check("R8 reset a_dout", a_dout, '0);
        check("R8 reset b_dout", b_dout, '0);
        @(negedge clk_a); rst_n = 1;

        fork
            begin
                // R1 then R2: second write while full must be dropped
                drive_a(1, 1, 1, 36'h123456789);
                drive_a(1, 1, 1, 36'hABCDE0123);
                drive_a(0, 0, 1, '0);
                repeat (30) drive_a(0, 0, 1, '0);
                for (int i = 0; i < 3000; i++)
                    drive_a($urandom_range(0, 1), $urandom_range(0, 1),
                            $urandom_range(0, 3) != 0, W'({$urandom(), $urandom()}));
                done_a = 1;
            end
            begin
                repeat (8) drive_b(0, 0, 1, '0);
                check("R2 R3 held word seen on port B", b_dout, 36'h123456789);
                check("R3 avail after sync", W'(b_rx_avail), W'(1));
                drive_b(1, 0, 1, '0);   // read takes the word
                drive_b(1, 0, 1, '0);   // read with nothing waiting
                #1;
                check("R5 word intact after read", b_dout, 36'h123456789);
                check("R4 avail cleared", W'(b_rx_avail), W'(0));
                for (int i = 0; i < 4000; i++)
                    drive_b($urandom_range(0, 1), $urandom_range(0, 1),
                            $urandom_range(0, 3) != 0, W'({$urandom(), $urandom()}));
                done_b = 1;
            end
        join
        repeat (6) @(negedge clk_a);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired done_a=%0d done_b=%0d", done_a, done_b);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule